// File: doc/BRIEF.md
# Configuration Request Retry Engine

This block sits in a PCIe root complex between the host port that issues configuration requests and the transmit and receive ports of the PCIe core. It takes one configuration read or write at a time and keeps the target, register offset, byte enables and write data in registers. It sends the request to the core and then waits for the completion. Any completion status other than success or Configuration Request Retry Status (CRS) ends the transaction with an error.

When CRS comes back, the engine either re-issues the stored request after a programmable pause, or ends the transaction with the synthesized Vendor ID word. The second case applies only to a read of offset 0 while the CRS visibility bit from the Root Control register is set. Retries are invisible to the host. The number of retries is bounded by a programmable limit, and passing that limit ends the transaction with a timeout status. A pause of about 1 µs is typical, for example `retryGap` = 249 at 250 MHz.

Top module: `cfg_retry_engine`

## Requirements
- R1: After reset, `reqReady` is 1 and both `txValid` and `rspValid` are 0.
- R2: A request is accepted when `reqValid` and `reqReady` are both 1. `reqReady` then stays 0 until the response handshake (`rspValid` and `rspReady` both 1) completes, so only one request is in flight at a time.
- R3: While `txValid` is 1 and `txReady` is 0, `txValid` stays 1 and all transmit fields stay unchanged.
- R4: A completion with `cplStatus` = 0 (successful) ends the transaction. `rspData` carries `cplData` and `rspStatus` = 0 (OK).
- R5: A CRS completion (`cplStatus` = 2) to a write is retried automatically at any offset and with any setting of `crsVisEn`. The re-issued request carries the same write flag, target, offset, byte enables and write data as the original, and no response is produced for it.
- R6: A CRS completion to a read at a nonzero dword offset (`offset[11:2]` ≠ 0) is retried even when `crsVisEn` = 1.
- R7: A CRS completion to a read of dword offset 0 while `crsVisEn` = 0 is retried.
- R8: A CRS completion to a read of dword offset 0 while `crsVisEn` = 1 is not retried. The response carries `rspData` = 0xFFFF0001 (Vendor ID half 0x0001, all other bits 1) and `rspStatus` = 0 (OK).
- R9: After a CRS completion is captured on a clock edge, `txValid` reasserts on the (`retryGap`+1)-th following edge, and not earlier.
- R10: Up to `retryLimit` retries are made, so at most `retryLimit`+1 sends occur. A CRS completion received when the limit is already used up ends the transaction with `rspStatus` = 2 (timeout) and `rspData` all ones.
- R11: A completion with any status other than 0 or 2 ends the transaction at once. It returns `rspStatus` = 1 (error) and `rspData` all ones, and nothing is re-sent.
- R12: While `rspValid` is 1 and `rspReady` is 0, `rspValid`, `rspData` and `rspStatus` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| crsVisEn | input | 1 | CRS software visibility enable from Root Control |
| retryGap | input | GAP_W | Pause in cycles before a retry |
| retryLimit | input | RETRY_W | Maximum number of retries |
| reqValid | input | 1 | Host request valid |
| reqReady | output | 1 | Engine can accept a request |
| reqWrite | input | 1 | 1 = configuration write |
| reqTarget | input | TGT_W | Bus/device/function of target |
| reqOffset | input | OFF_W | Register byte offset |
| reqBe | input | DATA_W/8 | Byte enables |
| reqWdata | input | DATA_W | Write data |
| rspValid | output | 1 | Final response valid |
| rspReady | input | 1 | Host takes response |
| rspData | output | DATA_W | Response data |
| rspStatus | output | 2 | 0 OK, 1 error, 2 timeout |
| txValid | output | 1 | Request to core valid |
| txReady | input | 1 | Core accepts request |
| txWrite | output | 1 | Request is a write |
| txTarget | output | TGT_W | Target to core |
| txOffset | output | OFF_W | Offset to core |
| txBe | output | DATA_W/8 | Byte enables to core |
| txWdata | output | DATA_W | Write data to core |
| cplValid | input | 1 | Completion from core valid |
| cplStatus | input | 3 | Completion status, 2 = CRS |
| cplData | input | DATA_W | Completion data |

## Verification
A corrupted request register shows up on the transmit fields of the first retry, which is at most `retryGap`+1 edges after the CRS completion. A wrong retry counter shows up as a send too many or too few before the timeout response. A wrong visibility decision shows up on the edge after the completion: either `rspValid` rises when a retry was due, or `txValid` returns when 0xFFFF0001 was due. A stuck gap counter either delays `txValid` past its exact edge or keeps it from ever returning, which the edge-exact gap measurement catches.

// File: rtl/cfg_retry_pkg.sv
package cfg_retry_pkg;

  localparam logic [2:0] CPL_SUCCESS = 3'd0;
  localparam logic [2:0] CPL_RETRY   = 3'd2;

  localparam logic [1:0] RSP_OK      = 2'd0;
  localparam logic [1:0] RSP_ERR     = 2'd1;
  localparam logic [1:0] RSP_TIMEOUT = 2'd2;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SEND,
    ST_WAIT,
    ST_GAP,
    ST_RESP
  } ctlState_e;

  typedef struct packed {
    logic latchReq;
    logic clrRetry;
    logic incRetry;
    logic loadGap;
    logic decGap;
    logic rspCpl;
    logic rspVendor;
    logic rspOnesErr;
    logic rspOnesTimeout;
  } dpStrobe_t;

endpackage

// File: rtl/cfg_retry_dp.sv
module cfg_retry_dp
  import cfg_retry_pkg::*;
#(
  parameter int TGT_W   = 16,
  parameter int OFF_W   = 12,
  parameter int DATA_W  = 32,
  parameter int GAP_W   = 16,
  parameter int RETRY_W = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  dpStrobe_t           strobe,
  input  logic [GAP_W-1:0]    retryGap,
  input  logic [RETRY_W-1:0]  retryLimit,
  input  logic                reqWrite,
  input  logic [TGT_W-1:0]    reqTarget,
  input  logic [OFF_W-1:0]    reqOffset,
  input  logic [DATA_W/8-1:0] reqBe,
  input  logic [DATA_W-1:0]   reqWdata,
  input  logic [DATA_W-1:0]   cplData,
  output logic                isWrite,
  output logic                isOffsetZero,
  output logic                retryExhausted,
  output logic                gapDone,
  output logic [TGT_W-1:0]    txTarget,
  output logic [OFF_W-1:0]    txOffset,
  output logic [DATA_W/8-1:0] txBe,
  output logic [DATA_W-1:0]   txWdata,
  output logic [DATA_W-1:0]   rspData,
  output logic [1:0]          rspStatus
);

  localparam int BE_W = DATA_W / 8;
  localparam logic [RETRY_W-1:0] RETRY_ONE = RETRY_W'(1);
  localparam logic [GAP_W-1:0]   GAP_ONE   = GAP_W'(1);
  localparam logic [DATA_W-1:0]  ALL_ONES  = '1;
  localparam logic [DATA_W-1:0]  VENDOR_WORD = {{(DATA_W-16){1'b1}}, 16'h0001};

  logic                writeQ;
  logic [TGT_W-1:0]    targetQ;
  logic [OFF_W-1:0]    offsetQ;
  logic [BE_W-1:0]     beQ;
  logic [DATA_W-1:0]   wdataQ;
  logic [RETRY_W-1:0]  retryCnt;
  logic [GAP_W-1:0]    gapCnt;
  logic [DATA_W-1:0]   rspDataQ;
  logic [1:0]          rspStatusQ;

  // request capture; held for every re-send
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      writeQ  <= 1'b0;
      targetQ <= '0;
      offsetQ <= '0;
      beQ     <= '0;
      wdataQ  <= '0;
    end else if (strobe.latchReq) begin
      writeQ  <= reqWrite;
      targetQ <= reqTarget;
      offsetQ <= reqOffset;
      beQ     <= reqBe;
      wdataQ  <= reqWdata;
    end
  end

  // retry count
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                retryCnt <= '0;
    else if (strobe.clrRetry) retryCnt <= '0;
    else if (strobe.incRetry) retryCnt <= retryCnt + RETRY_ONE;
  end

  // pause between CRS and re-send
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               gapCnt <= '0;
    else if (strobe.loadGap) gapCnt <= retryGap;
    else if (strobe.decGap)  gapCnt <= gapCnt - GAP_ONE;
  end

  // final response
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rspDataQ   <= '0;
      rspStatusQ <= RSP_OK;
    end else if (strobe.rspCpl) begin
      rspDataQ   <= cplData;
      rspStatusQ <= RSP_OK;
    end else if (strobe.rspVendor) begin
      rspDataQ   <= VENDOR_WORD;
      rspStatusQ <= RSP_OK;
    end else if (strobe.rspOnesErr) begin
      rspDataQ   <= ALL_ONES;
      rspStatusQ <= RSP_ERR;
    end else if (strobe.rspOnesTimeout) begin
      rspDataQ   <= ALL_ONES;
      rspStatusQ <= RSP_TIMEOUT;
    end
  end

  assign isWrite        = writeQ;
  assign isOffsetZero   = (offsetQ[OFF_W-1:2] == '0);
  assign retryExhausted = (retryCnt >= retryLimit);
  assign gapDone        = (gapCnt == '0);
  assign txTarget       = targetQ;
  assign txOffset       = offsetQ;
  assign txBe           = beQ;
  assign txWdata        = wdataQ;
  assign rspData        = rspDataQ;
  assign rspStatus      = rspStatusQ;

  // R10: the control never asks for a retry beyond the limit
  p_retry_bound_r10: assert property (@(posedge clk) disable iff (!rstN)
    strobe.incRetry |-> (retryCnt < retryLimit));

  // R11: an error strobe yields all ones with error status
  p_err_ones_r11: assert property (@(posedge clk) disable iff (!rstN)
    strobe.rspOnesErr |=> (rspDataQ == ALL_ONES) && (rspStatusQ == RSP_ERR));

  // R8: the visible CRS case yields the vendor word with OK status
  p_vendor_word_r8: assert property (@(posedge clk) disable iff (!rstN)
    strobe.rspVendor |=> (rspDataQ == VENDOR_WORD) && (rspStatusQ == RSP_OK));

endmodule

// File: rtl/cfg_retry_ctrl.sv
module cfg_retry_ctrl
  import cfg_retry_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       crsVisEn,
  input  logic       reqValid,
  input  logic       txReady,
  input  logic       rspReady,
  input  logic       cplValid,
  input  logic [2:0] cplStatus,
  input  logic       isWrite,
  input  logic       isOffsetZero,
  input  logic       retryExhausted,
  input  logic       gapDone,
  output logic       reqReady,
  output logic       txValid,
  output logic       rspValid,
  output dpStrobe_t  strobe
);

  ctlState_e state, stateNext;
  logic cplRetry;
  logic visibleCase;

  assign cplRetry    = (cplStatus == CPL_RETRY);
  assign visibleCase = crsVisEn && !isWrite && isOffsetZero;

  always_comb begin
    stateNext = state;
    strobe    = '0;
    unique case (state)
      ST_IDLE: begin
        if (reqValid) begin
          strobe.latchReq = 1'b1;
          strobe.clrRetry = 1'b1;
          stateNext       = ST_SEND;
        end
      end
      ST_SEND: begin
        if (txReady) stateNext = ST_WAIT;
      end
      ST_WAIT: begin
        if (cplValid) begin
          if (cplRetry) begin
            if (visibleCase) begin
              strobe.rspVendor = 1'b1;
              stateNext        = ST_RESP;
            end else if (retryExhausted) begin
              strobe.rspOnesTimeout = 1'b1;
              stateNext             = ST_RESP;
            end else begin
              strobe.incRetry = 1'b1;
              strobe.loadGap  = 1'b1;
              stateNext       = ST_GAP;
            end
          end else if (cplStatus == CPL_SUCCESS) begin
            strobe.rspCpl = 1'b1;
            stateNext     = ST_RESP;
          end else begin
            strobe.rspOnesErr = 1'b1;
            stateNext         = ST_RESP;
          end
        end
      end
      ST_GAP: begin
        if (gapDone) stateNext = ST_SEND;
        else         strobe.decGap = 1'b1;
      end
      ST_RESP: begin
        if (rspReady) stateNext = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  assign reqReady = (state == ST_IDLE);
  assign txValid  = (state == ST_SEND);
  assign rspValid = (state == ST_RESP);

  // R3: an offered request is not withdrawn
  p_tx_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    txValid && !txReady |=> txValid);

  // R8: visible CRS on a Vendor ID read answers on the next cycle
  p_visible_resp_r8: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_WAIT) && cplValid && cplRetry && visibleCase |=> rspValid);

  // R11: non-CRS failure answers on the next cycle without a re-send
  p_err_resp_r11: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_WAIT) && cplValid && !cplRetry && (cplStatus != CPL_SUCCESS)
      |=> rspValid && !txValid);

endmodule

// File: rtl/cfg_retry_engine.sv
module cfg_retry_engine
  import cfg_retry_pkg::*;
#(
  parameter int TGT_W   = 16,
  parameter int OFF_W   = 12,
  parameter int DATA_W  = 32,
  parameter int GAP_W   = 16,
  parameter int RETRY_W = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                crsVisEn,
  input  logic [GAP_W-1:0]    retryGap,
  input  logic [RETRY_W-1:0]  retryLimit,
  input  logic                reqValid,
  output logic                reqReady,
  input  logic                reqWrite,
  input  logic [TGT_W-1:0]    reqTarget,
  input  logic [OFF_W-1:0]    reqOffset,
  input  logic [DATA_W/8-1:0] reqBe,
  input  logic [DATA_W-1:0]   reqWdata,
  output logic                rspValid,
  input  logic                rspReady,
  output logic [DATA_W-1:0]   rspData,
  output logic [1:0]          rspStatus,
  output logic                txValid,
  input  logic                txReady,
  output logic                txWrite,
  output logic [TGT_W-1:0]    txTarget,
  output logic [OFF_W-1:0]    txOffset,
  output logic [DATA_W/8-1:0] txBe,
  output logic [DATA_W-1:0]   txWdata,
  input  logic                cplValid,
  input  logic [2:0]          cplStatus,
  input  logic [DATA_W-1:0]   cplData
);

  dpStrobe_t strobe;
  logic isOffsetZero;
  logic retryExhausted;
  logic gapDone;

  cfg_retry_ctrl uCtrl (
    .clk            (clk),
    .rstN           (rstN),
    .crsVisEn       (crsVisEn),
    .reqValid       (reqValid),
    .txReady        (txReady),
    .rspReady       (rspReady),
    .cplValid       (cplValid),
    .cplStatus      (cplStatus),
    .isWrite        (txWrite),
    .isOffsetZero   (isOffsetZero),
    .retryExhausted (retryExhausted),
    .gapDone        (gapDone),
    .reqReady       (reqReady),
    .txValid        (txValid),
    .rspValid       (rspValid),
    .strobe         (strobe)
  );

  cfg_retry_dp #(
    .TGT_W   (TGT_W),
    .OFF_W   (OFF_W),
    .DATA_W  (DATA_W),
    .GAP_W   (GAP_W),
    .RETRY_W (RETRY_W)
  ) uDp (
    .clk            (clk),
    .rstN           (rstN),
    .strobe         (strobe),
    .retryGap       (retryGap),
    .retryLimit     (retryLimit),
    .reqWrite       (reqWrite),
    .reqTarget      (reqTarget),
    .reqOffset      (reqOffset),
    .reqBe          (reqBe),
    .reqWdata       (reqWdata),
    .cplData        (cplData),
    .isWrite        (txWrite),
    .isOffsetZero   (isOffsetZero),
    .retryExhausted (retryExhausted),
    .gapDone        (gapDone),
    .txTarget       (txTarget),
    .txOffset       (txOffset),
    .txBe           (txBe),
    .txWdata        (txWdata),
    .rspData        (rspData),
    .rspStatus      (rspStatus)
  );

  // R5: stored request fields only change on an acceptance
  p_fields_stable_r5: assert property (@(posedge clk) disable iff (!rstN)
    !reqReady |=> $stable({txWrite, txTarget, txOffset, txBe, txWdata}));

  // R12: a pending response holds
  p_rsp_hold_r12: assert property (@(posedge clk) disable iff (!rstN)
    rspValid && !rspReady |=> rspValid && $stable(rspData) && $stable(rspStatus));

  // R2: no new acceptance while a transaction is in flight
  p_single_r2: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> !reqReady);

endmodule

// File: tb/cfg_retry_engine_test.sv
module cfg_retry_engine_test;

  localparam int CLK_PERIOD = 10;
  localparam int TGT_W = 16, OFF_W = 12, DATA_W = 32, GAP_W = 16, RETRY_W = 8;

  logic clk = 1'b0, rstN = 1'b0;
  logic crsVisEn = 1'b0;
  logic [GAP_W-1:0] retryGap = 16'd3;
  logic [RETRY_W-1:0] retryLimit = 8'd4;
  logic reqValid = 1'b0, reqReady, reqWrite = 1'b0;
  logic [TGT_W-1:0] reqTarget = '0;
  logic [OFF_W-1:0] reqOffset = '0;
  logic [3:0] reqBe = '0;
  logic [31:0] reqWdata = '0;
  logic rspValid, rspReady = 1'b0;
  logic [31:0] rspData;
  logic [1:0] rspStatus;
  logic txValid, txReady = 1'b0, txWrite;
  logic [TGT_W-1:0] txTarget;
  logic [OFF_W-1:0] txOffset;
  logic [3:0] txBe;
  logic [31:0] txWdata;
  logic cplValid = 1'b0;
  logic [2:0] cplStatus = '0;
  logic [31:0] cplData = '0;

  int checks = 0, errors = 0, cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfg_retry_engine #(.TGT_W(TGT_W), .OFF_W(OFF_W), .DATA_W(DATA_W),
                     .GAP_W(GAP_W), .RETRY_W(RETRY_W)) uut (
    .clk(clk), .rstN(rstN), .crsVisEn(crsVisEn), .retryGap(retryGap),
    .retryLimit(retryLimit), .reqValid(reqValid), .reqReady(reqReady),
    .reqWrite(reqWrite), .reqTarget(reqTarget), .reqOffset(reqOffset),
    .reqBe(reqBe), .reqWdata(reqWdata), .rspValid(rspValid),
    .rspReady(rspReady), .rspData(rspData), .rspStatus(rspStatus),
    .txValid(txValid), .txReady(txReady), .txWrite(txWrite),
    .txTarget(txTarget), .txOffset(txOffset), .txBe(txBe),
    .txWdata(txWdata), .cplValid(cplValid), .cplStatus(cplStatus),
    .cplData(cplData));

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 50000) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected below 50000 cycles", cycles);
      finishRun();
    end
  end

  task automatic issueReq(input logic w, input logic [11:0] off, input logic [3:0] be,
                          input logic [31:0] wd);
    while (!reqReady) @(negedge clk);
    reqValid = 1'b1; reqWrite = w; reqTarget = 16'h0A18;
    reqOffset = off; reqBe = be; reqWdata = wd;
    @(negedge clk);
    reqValid = 1'b0; reqWdata = 32'hDEAD0000; reqOffset = 12'hFFC;
    check("R2 reqReady low while busy", reqReady, 0);
  endtask

  task automatic serveTx(input logic w, input logic [11:0] off, input logic [3:0] be,
                         input logic [31:0] wd, input string tag);
    while (!txValid) @(negedge clk);
    check({tag, " txWrite"}, txWrite, w);
    check({tag, " txOffset"}, txOffset, off);
    check({tag, " txBe"}, txBe, be);
    check({tag, " txWdata"}, txWdata, wd);
    check({tag, " txTarget"}, txTarget, 16'h0A18);
    txReady = 1'b1;
    @(negedge clk);
    txReady = 1'b0;
  endtask

  task automatic giveCpl(input logic [2:0] st, input logic [31:0] d);
    cplValid = 1'b1; cplStatus = st; cplData = d;
    @(negedge clk);
    cplValid = 1'b0; cplStatus = 3'd0; cplData = '0;
  endtask

  task automatic gapAfterCrs(input int gap);
    int n = 1;
    while (!txValid && n < 1000) begin
      @(negedge clk);
      n++;
    end
    check("R9 retry edge after CRS", n, gap + 2);
  endtask

  task automatic takeRsp(input logic [31:0] d, input logic [1:0] st, input string tag);
    while (!rspValid) @(negedge clk);
    check({tag, " rspData"}, rspData, d);
    check({tag, " rspStatus"}, rspStatus, st);
    rspReady = 1'b1;
    @(negedge clk);
    rspReady = 1'b0;
    check("R2 reqReady back after handshake", reqReady, 1);
  endtask

  task automatic testReset();
    check("R1 reqReady", reqReady, 1);
    check("R1 txValid", txValid, 0);
    check("R1 rspValid", rspValid, 0);
  endtask

  task automatic testReadOk();
    issueReq(1'b0, 12'h008, 4'hF, 32'h0);
    @(negedge clk); @(negedge clk);
    check("R3 txValid held", txValid, 1);
    check("R3 txOffset held", txOffset, 12'h008);
    serveTx(1'b0, 12'h008, 4'hF, 32'h0, "R4");
    giveCpl(3'd0, 32'h1234ABCD);
    takeRsp(32'h1234ABCD, 2'd0, "R4");
  endtask

  task automatic testWriteRetry();
    crsVisEn = 1'b1; retryGap = 16'd3;
    issueReq(1'b1, 12'h000, 4'h3, 32'hCAFE0042);
    serveTx(1'b1, 12'h000, 4'h3, 32'hCAFE0042, "R5 first");
    giveCpl(3'd2, 32'h0);
    check("R5 no response on write CRS", rspValid, 0);
    gapAfterCrs(3);
    serveTx(1'b1, 12'h000, 4'h3, 32'hCAFE0042, "R5 resend1");
    giveCpl(3'd2, 32'h0);
    gapAfterCrs(3);
    serveTx(1'b1, 12'h000, 4'h3, 32'hCAFE0042, "R5 resend2");
    giveCpl(3'd0, 32'h0);
    takeRsp(32'h0, 2'd0, "R5");
  endtask

  task automatic testReadRetry(input logic vis, input logic [11:0] off, input string tag);
    crsVisEn = vis; retryGap = 16'd0;
    issueReq(1'b0, off, 4'hF, 32'h0);
    serveTx(1'b0, off, 4'hF, 32'h0, tag);
    giveCpl(3'd2, 32'h0);
    check({tag, " no early response"}, rspValid, 0);
    gapAfterCrs(0);
    serveTx(1'b0, off, 4'hF, 32'h0, tag);
    giveCpl(3'd0, 32'h00C0FFEE);
    takeRsp(32'h00C0FFEE, 2'd0, tag);
  endtask

  task automatic testVisible();
    crsVisEn = 1'b1;
    issueReq(1'b0, 12'h002, 4'h3, 32'h0);
    serveTx(1'b0, 12'h002, 4'h3, 32'h0, "R8");
    giveCpl(3'd2, 32'h0);
    check("R8 response next cycle", rspValid, 1);
    check("R8 no re-send", txValid, 0);
    takeRsp(32'hFFFF0001, 2'd0, "R8");
    check("R8 still no re-send", txValid, 0);
  endtask

  task automatic testLimit();
    int sends = 0;
    crsVisEn = 1'b0; retryGap = 16'd1; retryLimit = 8'd2;
    issueReq(1'b0, 12'h004, 4'hF, 32'h0);
    while (!rspValid && sends < 20) begin
      if (txValid) begin
        serveTx(1'b0, 12'h004, 4'hF, 32'h0, "R10");
        sends++;
        giveCpl(3'd2, 32'h0);
      end else @(negedge clk);
    end
    check("R10 send count", sends, 3);
    takeRsp(32'hFFFFFFFF, 2'd2, "R10");
    retryLimit = 8'd4;
  endtask

  task automatic testError();
    issueReq(1'b0, 12'h010, 4'hF, 32'h0);
    serveTx(1'b0, 12'h010, 4'hF, 32'h0, "R11");
    giveCpl(3'd1, 32'h5555AAAA);
    check("R11 response next cycle", rspValid, 1);
    check("R11 no re-send", txValid, 0);
    takeRsp(32'hFFFFFFFF, 2'd1, "R11");
  endtask

  task automatic testRspHold();
    issueReq(1'b0, 12'h00C, 4'hF, 32'h0);
    serveTx(1'b0, 12'h00C, 4'hF, 32'h0, "R12");
    giveCpl(3'd0, 32'h87654321);
    repeat (3) @(negedge clk);
    check("R12 rspValid held", rspValid, 1);
    check("R12 rspData held", rspData, 32'h87654321);
    check("R12 reqReady low", reqReady, 0);
    takeRsp(32'h87654321, 2'd0, "R12");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testReadOk();
    testWriteRetry();
    testReadRetry(1'b1, 12'h010, "R6");
    testReadRetry(1'b0, 12'h000, "R7");
    testVisible();
    testLimit();
    testError();
    testRspHold();
    repeat (2) @(negedge clk);
    finishRun();
  end

endmodule